// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Ninth-Bit Address Filter

This block turns an NRZ serial line into parallel characters. Before it reaches the block, the line has already been brought into the system clock domain. A baud-rate generator outside the block supplies a one-cycle tick at sixteen times the bit rate, and every sampling decision is made on those ticks.

Each character holds 8 or 9 data bits. Completed characters go into a two-place holding buffer, and the consumer drains that buffer with a read strobe. A stop bit received as space sets a framing flag, and that flag stays with its own character. If a character finishes while the buffer is full, the block raises a sticky overrun and stops taking new frames.

For multidrop buses, an address filter can drop every 9-bit character whose top bit is zero. With the filter on, a node sees only address characters.

Top module: `uart_addr_rx`

## Requirements
- R1: The line idles at mark (1). A frame starts with a space (0) start bit, which is confirmed by majority vote at mid-bit. A low pulse shorter than half a bit sends the receiver back to idle and stores nothing.
- R2: In 8-bit mode (nine_bit=0), eight data bits are taken least significant bit first and presented on data_out[7:0], with data_out[8]=0.
- R3: In 9-bit mode (nine_bit=1), nine data bits are taken LSB first. The last bit received appears on data_out[8].
- R4: Up to two completed characters are held and presented in arrival order. rx_valid is 1 while at least one character is held. A one-cycle rd_strobe while rx_valid=1 removes the oldest character.
- R5: When a character completes while two are already held, oerr goes to 1 and the character is dropped. oerr stays set and the start of new frames is ignored until rx_enable is driven low.
- R6: A stop bit voted as 0 sets ferr for that character only. ferr is shown together with the character's data while it is at the head of the buffer.
- R7: With nine_bit=1 and addr_en=1, a character whose ninth bit is 0 is discarded and one whose ninth bit is 1 is stored.
- R8: With nine_bit=0, addr_en has no effect and every character is stored.
- R9: Driving rx_enable low clears oerr and returns the receiver to idle within one cycle. Held characters are kept.
- R10: rx_idle is 1 exactly when no frame is in progress.
- R11: Each bit is decided by majority over ticks 7, 8 and 9 of its sixteen, so a wrong value on a single tick is outvoted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Serial line, already synchronised |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| addr_en | input | 1 | Enables the ninth-bit address filter |
| rx_enable | input | 1 | Receiver enable; low clears overrun |
| rd_strobe | input | 1 | Removes the head character |
| data_out | output | 9 | Head character |
| ferr | output | 1 | Framing flag of the head character |
| oerr | output | 1 | Sticky overrun flag |
| rx_valid | output | 1 | At least one character held |
| rx_idle | output | 1 | No frame in progress |

## Verification
The bench drives a short low pulse to confirm that a false start is dropped rather than turned into a character of all zeros. It also inverts a single tick inside a data bit, which a receiver sampling only once would store wrongly. A third character sent with the buffer full must leave the first two unchanged, and the start of a fourth must be ignored until rx_enable is dropped; a buffer that overwrote its head or kept receiving would fail here. The vector table sends 9-bit characters with and without the filter, plus 8-bit ones with the filter enabled. This catches a filter that drops the wrong ninth-bit value or acts in 8-bit mode. A framing error is followed by a clean character to show that the flag does not spill over.

// File: rtl/uart_addr_rx.sv
module uart_addr_rx #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_in,
  input  logic       baud_tick,
  input  logic       nine_bit,
  input  logic       addr_en,
  input  logic       rx_enable,
  input  logic       rd_strobe,
  output logic [8:0] data_out,
  output logic       ferr,
  output logic       oerr,
  output logic       rx_valid,
  output logic       rx_idle
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] S_A  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] S_B  = CW'(OSR/2);
  localparam logic [CW-1:0] S_C  = CW'(OSR/2 + 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [1:0] {IDLE, START, DATA, STOP} st_t;

  st_t         st;
  logic [CW-1:0] tcnt;
  logic [3:0]  bidx;
  logic [1:0]  smp;
  logic [8:0]  shreg;
  logic [9:0]  mem [2];
  logic        wp, rp;
  logic [1:0]  cnt;

  wire       vote   = (smp[0] & smp[1]) | (smp[0] & rx_in) | (smp[1] & rx_in);
  wire       decide = baud_tick && tcnt == S_C && st != IDLE;
  wire       done   = decide && st == STOP;
  wire [8:0] word   = nine_bit ? shreg : {1'b0, shreg[8:1]};
  wire       keep   = !(nine_bit && addr_en && !shreg[8]);
  wire       pop    = rd_strobe && cnt != 2'd0;
  wire       push   = done && keep && (cnt != 2'd2 || pop);
  wire       ovf    = done && keep && cnt == 2'd2 && !pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; tcnt <= '0; bidx <= '0; smp <= '0; shreg <= '0;
    end else if (!rx_enable) begin
      st <= IDLE;
    end else if (baud_tick) begin
      if (st == IDLE) begin
        if (!rx_in && !oerr) begin
          st   <= START;
          tcnt <= CW'(1);
        end
      end else begin
        tcnt <= (tcnt == LAST) ? '0 : tcnt + 1'b1;
        if (tcnt == S_A) smp[0] <= rx_in;
        if (tcnt == S_B) smp[1] <= rx_in;
        if (decide) begin
          unique case (st)
            START: if (vote) st <= IDLE;
                   else begin st <= DATA; bidx <= '0; end
            DATA: begin
              shreg <= {vote, shreg[8:1]};
              bidx  <= bidx + 1'b1;
              if (bidx == (nine_bit ? 4'd8 : 4'd7)) st <= STOP;
            end
            default: st <= IDLE;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem[0] <= '0; mem[1] <= '0; wp <= 1'b0; rp <= 1'b0; cnt <= '0; oerr <= 1'b0;
    end else begin
      if (push) begin
        mem[wp] <= {~vote, word};
        wp      <= ~wp;
      end
      if (pop) rp <= ~rp;
      cnt <= cnt + {1'b0, push} - {1'b0, pop};
      if (!rx_enable) oerr <= 1'b0;
      else if (ovf)   oerr <= 1'b1;
    end
  end

  assign data_out = mem[rp][8:0];
  assign ferr     = mem[rp][9];
  assign rx_valid = cnt != 2'd0;
  assign rx_idle  = st == IDLE;

  p_start_leaves_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_idle && rx_enable && !oerr && baud_tick && !rx_in |=> !rx_idle);
  p_oerr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    oerr && rx_enable |=> oerr);
  p_oerr_freezes_buffer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    oerr && rx_enable && !rd_strobe |=> $stable(cnt) && rx_idle);
  p_pop_drops_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rd_strobe && !push |=> cnt == $past(cnt) - 2'd1);
  p_disable_resets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> rx_idle && !oerr);
endmodule

// File: tb/test_uart_addr_rx.sv
module test_uart_addr_rx;
  logic clk = 0, rst_n = 0, rx_in = 1, baud_tick = 0;
  logic nine_bit = 0, addr_en = 0, rx_enable = 1, rd_strobe = 0;
  logic [8:0] data_out;
  logic ferr, oerr, rx_valid, rx_idle;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  uart_addr_rx i_uart_addr_rx (.*);

  always #10 clk = ~clk;

  initial forever begin
    repeat (3) @(negedge clk);
    baud_tick = 1;
    @(negedge clk);
    baud_tick = 0;
  end

  // {nine, addr_en, data[8:0], stop, accepted}
  localparam logic [12:0] VEC [8] = '{
    {1'b0, 1'b0, 9'h1A5, 1'b1, 1'b1},
    {1'b0, 1'b0, 9'h03C, 1'b0, 1'b1},
    {1'b1, 1'b0, 9'h155, 1'b1, 1'b1},
    {1'b1, 1'b0, 9'h0AA, 1'b1, 1'b1},
    {1'b1, 1'b1, 9'h0AA, 1'b1, 1'b0},
    {1'b1, 1'b1, 9'h1C3, 1'b1, 1'b1},
    {1'b0, 1'b1, 9'h081, 1'b1, 1'b1},
    {1'b1, 1'b1, 9'h100, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rx_in = v;
    repeat (n) @(posedge clk iff baud_tick);
    #1;
  endtask

  task automatic send(input logic [8:0] d, input int nb, input logic stop, input int gbit);
    hold(1'b0, 16);
    for (int i = 0; i < nb; i++) begin
      if (i == gbit) begin
        hold(d[i], 8); hold(~d[i], 1); hold(d[i], 7);
      end else hold(d[i], 16);
    end
    hold(stop, 16);
    hold(1'b1, 24);
  endtask

  task automatic rd;
    @(negedge clk) rd_strobe = 1;
    @(negedge clk) rd_strobe = 0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 reset idle", {9'b0, rx_idle}, 10'd1);
    check("R4 reset empty", {9'b0, rx_valid}, 10'd0);
    check("R5 reset oerr", {9'b0, oerr}, 10'd0);
    hold(1'b1, 4);

    for (int k = 0; k < 8; k++) begin
      logic [12:0] v = VEC[k];
      logic [8:0] exp = v[12] ? v[10:2] : {1'b0, v[9:2]};
      nine_bit = v[12]; addr_en = v[11];
      send(v[10:2], v[12] ? 9 : 8, v[1], -1);
      @(negedge clk);
      check($sformatf("R7/R8 vec%0d stored", k), {9'b0, rx_valid}, {9'b0, v[0]});
      if (v[0]) begin
        check($sformatf("R2/R3 vec%0d data", k), {1'b0, data_out}, {1'b0, exp});
        check($sformatf("R6 vec%0d ferr", k), {9'b0, ferr}, {9'b0, ~v[1]});
        rd();
        check($sformatf("R4 vec%0d popped", k), {9'b0, rx_valid}, 10'd0);
      end
      check($sformatf("R10 vec%0d idle", k), {9'b0, rx_idle}, 10'd1);
    end

    nine_bit = 0; addr_en = 0;
    hold(1'b0, 4);
    check("R10 busy during start", {9'b0, rx_idle}, 10'd0);
    hold(1'b1, 24);
    check("R1 glitch rejected idle", {9'b0, rx_idle}, 10'd1);
    check("R1 glitch stores nothing", {9'b0, rx_valid}, 10'd0);

    send(9'h05A, 8, 1'b1, 0);
    @(negedge clk);
    check("R11 single-tick disturbance outvoted", {1'b0, data_out}, 10'h05A);
    rd();

    send(9'h011, 8, 1'b1, -1);
    send(9'h022, 8, 1'b1, -1);
    check("R5 no overrun at two", {9'b0, oerr}, 10'd0);
    send(9'h033, 8, 1'b1, -1);
    check("R5 overrun raised", {9'b0, oerr}, 10'd1);
    hold(1'b0, 16);
    check("R5 start ignored while overrun", {9'b0, rx_idle}, 10'd1);
    hold(1'b1, 16);
    check("R4 first kept", {1'b0, data_out}, 10'h011);
    rd();
    check("R4 second kept", {1'b0, data_out}, 10'h022);
    rd();
    check("R4 third dropped", {9'b0, rx_valid}, 10'd0);
    check("R5 oerr persists after reads", {9'b0, oerr}, 10'd1);

    @(negedge clk) rx_enable = 0;
    @(negedge clk);
    check("R9 oerr cleared", {9'b0, oerr}, 10'd0);
    check("R9 idle when disabled", {9'b0, rx_idle}, 10'd1);
    rx_enable = 1;
    send(9'h0E7, 8, 1'b1, -1);
    @(negedge clk);
    check("R9 reception resumes", {rx_valid, data_out}, {1'b1, 9'h0E7});
    rd();

    finish_run();
  end
endmodule